// File: doc/BRIEF.md
# Indexed Extension Word Decoder

This block turns the 16-bit extension word of an indexed addressing mode into the quantities an address generator needs. Once started, it fetches the extension word from the instruction stream at a given byte offset. It reads the index register that the word names from a register-file read port, and then sign-extends and scales that index. In the full format it also fetches an optional base displacement and an optional outer displacement, each of which may be absent, one word or two words long.

The results are a combined base displacement, an outer displacement, a base-suppress flag, a memory-indirect flag and an illegal-combination flag. They appear together with a one-cycle completion pulse. The fetch offset that remains at completion points just past the last word consumed, so the caller can continue decoding from there. Forming the final address is left to the surrounding logic.

Top module: `ixd_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start, `done_o`, `fetch_req_o`, `illegal_o`, both flags and both displacements read zero.
- R2: A start loads `start_off_i` as the fetch offset. Every word accepted (`fetch_req_o` and `fetch_ack_i` high at a rising edge) advances `fetch_off_o` by 2. At completion `fetch_off_o` equals the start offset plus 2 × (1 + displacement words fetched).
- R3: Extension bits [15:12] drive `rf_sel_o` to pick one of 16 registers. Bit 11 = 0 uses the low 16 bits of `rf_data_i` sign-extended to 32; bit 11 = 1 uses all 32 bits.
- R4: The index is shifted left by the value of bits [10:9], multiplying it by 1, 2, 4 or 8.
- R5: Bit 8 = 0 (brief format): base = sign-extended bits [7:0] + scaled index, outer = 0, both flags 0, no further word is fetched, and bits 6 and 2 carry no meaning.
- R6: Bit 8 = 1 (full format): `base_suppress_o` equals bit 7.
- R7: Full format: bits [5:4] size the base displacement and bits [1:0] the outer one. 0 or 1 means absent (value 0), 2 means one word (sign-extended), and 3 means two words (first word is the high half). Base words are fetched before outer words.
- R8: Full format: `mem_indirect_o` is 1 whenever bits [1:0] are non-zero, including the absent-size code 1.
- R9: Full format, by bits {6,2}: 00 adds the index to the base displacement, 01 adds it to the outer displacement, and 10 uses no index.
- R10: Full format with bits 6 and 2 both set: `illegal_o` is raised with `done_o`, no displacement word is fetched, and both displacements and both flags read 0.
- R11: `done_o` is a one-cycle pulse. With `fetch_ack_i` high it rises on rising edge 4 + N, where the edge that samples `start_i` is edge 1 and N is the number of displacement words. A stalled request keeps `fetch_req_o` high and `fetch_off_o` unchanged. A start seen while a decode is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a decode (taken only when idle) |
| start_off_i | input | OFF_W | Byte offset of the extension word |
| fetch_req_o | output | 1 | Word fetch request |
| fetch_off_o | output | OFF_W | Offset of the requested word; after completion, offset past the last word |
| fetch_ack_i | input | 1 | Fetched word is valid this cycle |
| fetch_data_i | input | 16 | Fetched instruction-stream word |
| rf_sel_o | output | 4 | Index register select |
| rf_data_i | input | 32 | Selected register value |
| done_o | output | 1 | Results valid (one-cycle pulse) |
| illegal_o | output | 1 | Illegal index/indirect combination |
| base_suppress_o | output | 1 | Base register suppressed |
| mem_indirect_o | output | 1 | Memory indirection required |
| base_disp_o | output | 32 | Combined base displacement |
| outer_disp_o | output | 32 | Combined outer displacement |

## Verification
Latency here is counted in rising edges, with the edge that samples `start_i` as the first. With no stalls, a brief-format or illegal word completes on edge 4, and each displacement word adds one edge. A stalled fetch adds one edge for every cycle that `fetch_req_o` is held. The bench samples on falling edges only and counts cycles from the start edge up to the first sample that shows `done_o`. It also counts the sampled cycles with `fetch_req_o` high and with `fetch_ack_i` high. It then requires the latency to equal 3 plus the number of request cycles, and the accepted words to equal one plus the displacement words the requirement implies. Results and the final offset are read in the same sample that shows `done_o`.

// File: rtl/ixd_pkg.sv
// Shared types and helpers for the indexed extension word decoder.
// Assumes the fixed 16-bit extension word layout with a 32-bit long operand.
package ixd_pkg;

    localparam int WORD_W    = 16;
    localparam int LONG_W    = 2 * WORD_W;
    localparam int REG_SEL_W = 4;
    localparam int BYTE_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXT,
        ST_IDX,
        ST_BASE,
        ST_OUTER,
        ST_DONE
    } ixd_state_e;

    // Field positions follow the extension word bit layout.
    typedef struct packed {
        logic [REG_SEL_W-1:0] reg_sel;   // [15:12]
        logic                 long_idx;  // [11]
        logic [1:0]           scale;     // [10:9]
        logic                 full;      // [8]
        logic                 base_sup;  // [7]
        logic                 no_idx;    // [6]
        logic [1:0]           bd_sz;     // [5:4]
        logic                 rsv;       // [3]
        logic                 post_idx;  // [2]
        logic [1:0]           od_sz;     // [1:0]
    } ext_word_t;

    // Number of 16-bit words a displacement size code consumes.
    function automatic logic [1:0] size_words(input logic [1:0] code);
        case (code)
            2'd2:    size_words = 2'd1;
            2'd3:    size_words = 2'd2;
            default: size_words = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ixd_ctrl.sv
// Sequencer: fetches the extension word, lets the index be captured,
// then fetches base and outer displacement words in that order.
// Assumes the fetch port accepts a word when req and ack are both high.
module ixd_ctrl
    import ixd_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OFF_W-1:0]  start_off_i,
    input  logic              fetch_ack_i,
    input  logic [WORD_W-1:0] fetch_data_i,
    output logic              fetch_req_o,
    output logic [OFF_W-1:0]  fetch_off_o,
    output ext_word_t         ext_o,
    output logic              clr_o,
    output logic              idx_cap_o,
    output logic [1:0]        shift_o,
    output logic              finish_o
);

    localparam logic [OFF_W-1:0] WORD_BYTES = OFF_W'(WORD_W / BYTE_W);

    ixd_state_e       state_q;
    ext_word_t        ext_q;
    logic [OFF_W-1:0] off_q;
    logic [1:0]       bd_left_q;
    logic [1:0]       od_left_q;
    logic             take;
    logic             bad_combo;
    logic [1:0]       bd_words;
    logic [1:0]       od_words;

    // Request decode and the per-word acceptance strobe.
    always_comb begin
        fetch_req_o = (state_q == ST_EXT) || (state_q == ST_BASE) || (state_q == ST_OUTER);
        take        = fetch_req_o && fetch_ack_i;
        bad_combo   = ext_q.full && ext_q.no_idx && ext_q.post_idx;
        bd_words    = size_words(ext_q.bd_sz);
        od_words    = size_words(ext_q.od_sz);
    end

    // State, offset, extension word and remaining-word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ext_q     <= '0;
            off_q     <= '0;
            bd_left_q <= '0;
            od_left_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        off_q   <= start_off_i;
                        state_q <= ST_EXT;
                    end
                end
                ST_EXT: begin
                    if (take) begin
                        ext_q   <= ext_word_t'(fetch_data_i);
                        off_q   <= off_q + WORD_BYTES;
                        state_q <= ST_IDX;
                    end
                end
                ST_IDX: begin
                    if (!ext_q.full || bad_combo) begin
                        state_q <= ST_DONE;
                    end else begin
                        bd_left_q <= bd_words;
                        od_left_q <= od_words;
                        if (bd_words != 2'd0)      state_q <= ST_BASE;
                        else if (od_words != 2'd0) state_q <= ST_OUTER;
                        else                       state_q <= ST_DONE;
                    end
                end
                ST_BASE: begin
                    if (take) begin
                        off_q     <= off_q + WORD_BYTES;
                        bd_left_q <= bd_left_q - 2'd1;
                        if (bd_left_q == 2'd1)
                            state_q <= (od_left_q != 2'd0) ? ST_OUTER : ST_DONE;
                    end
                end
                ST_OUTER: begin
                    if (take) begin
                        off_q     <= off_q + WORD_BYTES;
                        od_left_q <= od_left_q - 2'd1;
                        if (od_left_q == 2'd1)
                            state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Strobes for the datapath pieces.
    always_comb begin
        fetch_off_o = off_q;
        ext_o       = ext_q;
        clr_o       = (state_q == ST_IDLE) && start_i;
        idx_cap_o   = (state_q == ST_IDX);
        shift_o[0]  = (state_q == ST_BASE) && take;
        shift_o[1]  = (state_q == ST_OUTER) && take;
        finish_o    = (state_q == ST_DONE);
    end

endmodule

// File: rtl/ixd_index_scale.sv
// Index conditioning: optional sign extension of the low half, then scaling.
// Purely combinational; assumes the register value is already selected.
module ixd_index_scale
    import ixd_pkg::*;
(
    input  logic [LONG_W-1:0] reg_val_i,
    input  logic              long_i,
    input  logic [1:0]        scale_i,
    output logic [LONG_W-1:0] idx_o
);

    logic [LONG_W-1:0] sized;

    // Choose width, then shift by the scale code.
    always_comb begin
        sized = long_i ? reg_val_i
                       : {{(LONG_W-WORD_W){reg_val_i[WORD_W-1]}}, reg_val_i[WORD_W-1:0]};
        idx_o = sized << scale_i;
    end

endmodule

// File: rtl/ixd_disp_collect.sv
// Displacement accumulator: the first word is sign-extended; a second word
// shifts it into the high half. Assumes clr precedes every new operand.
module ixd_disp_collect #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic [IN_W-1:0]  word_i,
    output logic [OUT_W-1:0] acc_o
);

    logic [OUT_W-1:0] acc_q;
    logic             first_q;

    // Accumulate words high half first.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q   <= '0;
            first_q <= 1'b1;
        end else if (shift_i) begin
            first_q <= 1'b0;
            if (first_q)
                acc_q <= {{(OUT_W-IN_W){word_i[IN_W-1]}}, word_i};
            else
                acc_q <= {acc_q[OUT_W-IN_W-1:0], word_i};
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/ixd_result.sv
// Combines the index with the collected displacements by format and index
// placement. Combinational; assumes all inputs are stable when used.
module ixd_result
    import ixd_pkg::*;
(
    input  ext_word_t         ext_i,
    input  logic [LONG_W-1:0] idx_i,
    input  logic [LONG_W-1:0] bd_i,
    input  logic [LONG_W-1:0] od_i,
    output logic [LONG_W-1:0] base_o,
    output logic [LONG_W-1:0] outer_o,
    output logic              illegal_o,
    output logic              base_sup_o,
    output logic              mem_ind_o
);

    logic [WORD_W-1:0] raw;
    logic [LONG_W-1:0] short_disp;

    // Brief displacement taken from the low byte of the word.
    always_comb begin
        raw        = ext_i;
        short_disp = {{(LONG_W-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
    end

    // Format and placement selection.
    always_comb begin
        base_o     = '0;
        outer_o    = '0;
        illegal_o  = 1'b0;
        base_sup_o = 1'b0;
        mem_ind_o  = 1'b0;
        if (!ext_i.full) begin
            base_o = short_disp + idx_i;
        end else if (ext_i.no_idx && ext_i.post_idx) begin
            illegal_o = 1'b1;
        end else begin
            base_sup_o = ext_i.base_sup;
            mem_ind_o  = (ext_i.od_sz != 2'd0);
            case ({ext_i.no_idx, ext_i.post_idx})
                2'b00: begin
                    base_o  = bd_i + idx_i;
                    outer_o = od_i;
                end
                2'b01: begin
                    base_o  = bd_i;
                    outer_o = od_i + idx_i;
                end
                default: begin
                    base_o  = bd_i;
                    outer_o = od_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/ixd_decoder.sv
// Top of the indexed extension word decoder. Fetches the extension word and
// any displacement words, reads and scales the index, and presents the
// combined results with a one-cycle done pulse. Results hold until the next
// completion. Assumes a same-cycle register-file read port.
module ixd_decoder
    import ixd_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [OFF_W-1:0]     start_off_i,
    output logic                 fetch_req_o,
    output logic [OFF_W-1:0]     fetch_off_o,
    input  logic                 fetch_ack_i,
    input  logic [WORD_W-1:0]    fetch_data_i,
    output logic [REG_SEL_W-1:0] rf_sel_o,
    input  logic [LONG_W-1:0]    rf_data_i,
    output logic                 done_o,
    output logic                 illegal_o,
    output logic                 base_suppress_o,
    output logic                 mem_indirect_o,
    output logic [LONG_W-1:0]    base_disp_o,
    output logic [LONG_W-1:0]    outer_disp_o
);

    localparam int N_DISP = 2;   // base and outer collectors

    ext_word_t         ext;
    logic              clr;
    logic              idx_cap;
    logic              finish;
    logic [N_DISP-1:0] shift;
    logic [LONG_W-1:0] idx_now;
    logic [LONG_W-1:0] idx_q;
    logic [LONG_W-1:0] disp_acc [N_DISP];
    logic [LONG_W-1:0] base_c;
    logic [LONG_W-1:0] outer_c;
    logic              ill_c;
    logic              bs_c;
    logic              mi_c;

    ixd_ctrl #(.OFF_W(OFF_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_off_i  (start_off_i),
        .fetch_ack_i  (fetch_ack_i),
        .fetch_data_i (fetch_data_i),
        .fetch_req_o  (fetch_req_o),
        .fetch_off_o  (fetch_off_o),
        .ext_o        (ext),
        .clr_o        (clr),
        .idx_cap_o    (idx_cap),
        .shift_o      (shift),
        .finish_o     (finish)
    );

    assign rf_sel_o = ext.reg_sel;

    ixd_index_scale u_scale (
        .reg_val_i (rf_data_i),
        .long_i    (ext.long_idx),
        .scale_i   (ext.scale),
        .idx_o     (idx_now)
    );

    // Hold the scaled index once read.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (idx_cap) idx_q <= idx_now;
    end

    for (genvar g = 0; g < N_DISP; g++) begin : g_disp
        ixd_disp_collect #(.IN_W(WORD_W), .OUT_W(LONG_W)) u_coll (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr),
            .shift_i (shift[g]),
            .word_i  (fetch_data_i),
            .acc_o   (disp_acc[g])
        );
    end

    ixd_result u_res (
        .ext_i      (ext),
        .idx_i      (idx_q),
        .bd_i       (disp_acc[0]),
        .od_i       (disp_acc[1]),
        .base_o     (base_c),
        .outer_o    (outer_c),
        .illegal_o  (ill_c),
        .base_sup_o (bs_c),
        .mem_ind_o  (mi_c)
    );

    // Register results and the done pulse at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o          <= 1'b0;
            illegal_o       <= 1'b0;
            base_suppress_o <= 1'b0;
            mem_indirect_o  <= 1'b0;
            base_disp_o     <= '0;
            outer_disp_o    <= '0;
        end else begin
            done_o <= finish;
            if (finish) begin
                illegal_o       <= ill_c;
                base_suppress_o <= bs_c;
                mem_indirect_o  <= mi_c;
                base_disp_o     <= base_c;
                outer_disp_o    <= outer_c;
            end
        end
    end

endmodule

// File: rtl/ixd_decoder_chk.sv
// Port-level temporal checks for ixd_decoder, bound to every instance.
module ixd_decoder_chk #(
    parameter int OFF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_req_o,
    input logic             fetch_ack_i,
    input logic [OFF_W-1:0] fetch_off_o,
    input logic             done_o,
    input logic             illegal_o,
    input logic             base_suppress_o,
    input logic             mem_indirect_o,
    input logic [31:0]      base_disp_o,
    input logic [31:0]      outer_disp_o
);

    // Done lasts a single cycle (R11).
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // A stalled request holds its offset (R11).
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_off_o));

    // Each accepted word moves the offset by two bytes (R2).
    assert_off_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o && fetch_ack_i |=> fetch_off_o == $past(fetch_off_o) + OFF_W'(2));

    // Illegal completion carries zero results and flags (R10).
    assert_illegal_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && illegal_o |-> base_disp_o == 32'd0 && outer_disp_o == 32'd0
                                && !base_suppress_o && !mem_indirect_o);

    // No fetch is pending when results are presented (R11).
    assert_idle_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !fetch_req_o);

endmodule

bind ixd_decoder ixd_decoder_chk #(.OFF_W(OFF_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_req_o     (fetch_req_o),
    .fetch_ack_i     (fetch_ack_i),
    .fetch_off_o     (fetch_off_o),
    .done_o          (done_o),
    .illegal_o       (illegal_o),
    .base_suppress_o (base_suppress_o),
    .mem_indirect_o  (mem_indirect_o),
    .base_disp_o     (base_disp_o),
    .outer_disp_o    (outer_disp_o)
);

// File: tb/tb_ixd_decoder.sv
// Vector-table bench for ixd_decoder, followed by directed reset, stall and
// restart cases.
module tb_ixd_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [15:0] start_off_i;
    logic        fetch_req_o;
    logic [15:0] fetch_off_o;
    logic        fetch_ack_i;
    logic [15:0] fetch_data_i;
    logic [3:0]  rf_sel_o;
    logic [31:0] rf_data_i;
    logic        done_o;
    logic        illegal_o;
    logic        base_suppress_o;
    logic        mem_indirect_o;
    logic [31:0] base_disp_o;
    logic [31:0] outer_disp_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    ixd_decoder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_off_i(start_off_i),
        .fetch_req_o(fetch_req_o), .fetch_off_o(fetch_off_o), .fetch_ack_i(fetch_ack_i),
        .fetch_data_i(fetch_data_i), .rf_sel_o(rf_sel_o), .rf_data_i(rf_data_i),
        .done_o(done_o), .illegal_o(illegal_o), .base_suppress_o(base_suppress_o),
        .mem_indirect_o(mem_indirect_o), .base_disp_o(base_disp_o), .outer_disp_o(outer_disp_o)
    );

    // Vector: ext, w0..w3, register value, base, outer, {illegal,bsup,mind}, displacement words.
    localparam int NV = 9;
    localparam logic [181:0] VEC [NV] = '{
        {16'h32F0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'h0001_8004, 32'hFFFE_FFF8, 32'h0000_0000, 3'b000, 3'd0},
        {16'hAE44, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'h1000_0003, 32'h8000_005C, 32'h0000_0000, 3'b000, 3'd0},
        {16'h1120, 16'hFFFE, 16'h0000, 16'h0000, 16'h0000, 32'h0000_0100, 32'h0000_00FE, 32'h0000_0000, 3'b000, 3'd1},
        {16'hFDB6, 16'h1234, 16'h5678, 16'h8000, 16'h0000, 32'h0000_0010, 32'h1234_5678, 32'hFFFF_8040, 3'b011, 3'd3},
        {16'h5153, 16'hABCD, 16'h0001, 16'h0000, 16'h0000, 32'h7777_7777, 32'h0000_0000, 32'hABCD_0001, 3'b001, 3'd2},
        {16'h0301, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'hFFFF_7FFF, 32'h0000_FFFE, 32'h0000_0000, 3'b001, 3'd0},
        {16'h21E6, 16'h1111, 16'h2222, 16'h0000, 16'h0000, 32'h1234_5678, 32'h0000_0000, 32'h0000_0000, 3'b100, 3'd0},
        {16'h7B24, 16'h8001, 16'h0000, 16'h0000, 16'h0000, 32'h4000_0001, 32'hFFFF_8001, 32'h8000_0002, 3'b000, 3'd1},
        {16'hC733, 16'h0000, 16'h1000, 16'hFFFF, 16'hFFF0, 32'h1234_FFFF, 32'h0000_0FF8, 32'hFFFF_FFF0, 3'b001, 3'd4}
    };

    logic [181:0] cur_vec = '0;
    logic [15:0]  cur_start = '0;
    logic [15:0]  widx;

    // Instruction stream and register file model.
    always_comb begin
        widx = (fetch_off_o - cur_start) >> 1;
        case (widx)
            16'd0:   fetch_data_i = cur_vec[181:166];
            16'd1:   fetch_data_i = cur_vec[165:150];
            16'd2:   fetch_data_i = cur_vec[149:134];
            16'd3:   fetch_data_i = cur_vec[133:118];
            16'd4:   fetch_data_i = cur_vec[117:102];
            default: fetch_data_i = 16'hBAD0;
        endcase
        rf_data_i = (rf_sel_o == cur_vec[181:178]) ? cur_vec[101:70]
                                                   : {16'hDEAD, 12'h000, rf_sel_o};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    int lat, words, reqs;

    // Run one decode; stall toggles ack, restart pulses start mid-run.
    task automatic run(input logic [181:0] v, input logic [15:0] so,
                       input bit stall, input bit restart);
        @(negedge clk);
        cur_vec     = v;
        cur_start   = so;
        start_off_i = so;
        start_i     = 1'b1;
        fetch_ack_i = 1'b1;
        lat = 0; words = 0; reqs = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            lat++;
            start_i     = (restart && lat == 2);
            fetch_ack_i = stall ? lat[0] : 1'b1;
            #1;
            if (done_o) break;
            if (fetch_req_o) reqs++;
            if (fetch_req_o && fetch_ack_i) words++;
        end
        start_i = 1'b0;
    endtask

    task automatic check_vec(input logic [181:0] v, input logic [15:0] so, input bit stall);
        int nw;
        nw = int'(v[2:0]);
        chk("R11 done seen", {31'd0, done_o}, 32'd1);
        if (stall) chk("R11 stalled latency", lat, reqs + 3);
        else       chk("R11 latency", lat, 4 + nw);
        chk("R7 words fetched", words, 1 + nw);
        chk("R2 final offset", {16'd0, fetch_off_o}, {16'd0, so + 16'(2 * (1 + nw))});
        chk("R5 R9 R3 R4 base", base_disp_o, v[69:38]);
        chk("R9 R7 outer", outer_disp_o, v[37:6]);
        chk("R6 R8 R10 flags", {29'd0, illegal_o, base_suppress_o, mem_indirect_o}, {29'd0, v[5:3]});
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b1; start_off_i = 16'h5555; fetch_ack_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 done in reset", {31'd0, done_o}, 32'd0);
        chk("R1 req in reset", {31'd0, fetch_req_o}, 32'd0);
        start_i = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 outputs after reset", base_disp_o | outer_disp_o |
            {29'd0, illegal_o, base_suppress_o, mem_indirect_o}, 32'd0);
        chk("R1 idle after reset", {30'd0, done_o, fetch_req_o}, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            run(VEC[i], 16'h0100 + 16'(i * 32), 1'b0, 1'b0);
            check_vec(VEC[i], 16'h0100 + 16'(i * 32), 1'b0);
        end

        // R11: stalled fetches on a long/word full form
        run(VEC[3], 16'h2000, 1'b1, 1'b0);
        check_vec(VEC[3], 16'h2000, 1'b1);
        chk("R11 stall added cycles", {31'd0, (lat > 7)}, 32'd1);

        // R11: start during a decode has no effect; results then hold
        run(VEC[8], 16'h3000, 1'b0, 1'b1);
        check_vec(VEC[8], 16'h3000, 1'b0);
        repeat (6) begin
            @(negedge clk);
            chk("R11 no second done", {30'd0, done_o, fetch_req_o}, 32'd0);
        end
        chk("R11 results held", outer_disp_o, 32'hFFFF_FFF0);

        // R10: illegal directly after a long fetch, no words consumed
        run(VEC[6], 16'h4000, 1'b1, 1'b0);
        check_vec(VEC[6], 16'h4000, 1'b1);

        // R1: reset mid-decode clears everything
        @(negedge clk);
        cur_vec = VEC[8]; cur_start = 16'h5000; start_off_i = 16'h5000; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) begin
            @(negedge clk);
            chk("R1 quiet after mid reset", {30'd0, done_o, fetch_req_o}, 32'd0);
        end
        chk("R1 results cleared", base_disp_o | outer_disp_o, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule